// File: doc/BRIEF.md
# SPI Master Word Shifter

This block is the serial core of an SPI master. It moves one word at a time out on the data output line and collects one word at a time from the data input line. It generates the serial clock from the module clock. A caller hands it a transmit word through a valid/ready pair, and each received word comes back on a 32-bit output together with a one-cycle strobe. The caller chooses the baud rate, the word width (2 to 32 bits), the clock polarity, the resting clock level, the sampling phase, the bit order and an internal loopback path. These settings are captured only while the enable input is low, which is the configuration mode. While the engine is enabled they are frozen.

The engine is a three-state machine. In `ST_IDLE` no word is in flight and the serial clock rests at the programmed idle level. The transition *start* moves it to `ST_LEAD` when a transmit word is accepted, or when the transmitter is switched off and the receiver is on. In `ST_LEAD` the serial clock sits at the polarity level for one half period. The transition *first-edge* then moves it to `ST_TRAIL`, where the clock sits at the opposite level. At the end of `ST_TRAIL` there are two transitions. *next-bit* returns to `ST_LEAD`. *word-done* returns to `ST_IDLE` after the last bit. Dropping the enable input at any time takes the transition *abort* back to `ST_IDLE`. With the transmitter off, the engine keeps clocking back-to-back words, which makes a receive-only mode.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset `busy`, `rx_valid`, `mosi`, `tx_ready` and `sclk` are all 0.
- R2: Each serial clock half period lasts `cfg_divider`+1 module clocks. A word of N bits keeps `busy` high for exactly 2·N·(`cfg_divider`+1) cycles.
- R3: The word width is `cfg_width_m1`+1 bits, and a value of 0 is treated as 1, giving a 2-bit word. Transmit bits above the width are ignored. A received word is right-justified with all higher bits 0.
- R4: With `cfg_sample_first`=1, each bit is on `mosi` before the first clock edge of its bit time and is sampled on that first edge. With `cfg_sample_first`=0, `mosi` changes on the first edge and sampling happens on the second edge.
- R5: During a word the first half of every bit time has `sclk` = `cfg_polarity`. While no word is in flight `sclk` = `cfg_idle_level`.
- R6: `cfg_msb_first`=1 sends and receives bit N-1 first. `cfg_msb_first`=0 sends and receives bit 0 first.
- R7: With `cfg_loopback`=1 the receiver samples the engine's own `mosi`, and `miso` has no effect on the received word.
- R8: With `tx_disable`=1, `tx_ready` is 0 and `mosi` is 0. If `rx_disable`=0 the engine clocks words back to back and returns each word received on `miso`.
- R9: A word started with `rx_disable`=1 produces no `rx_valid`, and `rx_data` keeps its earlier value.
- R10: Divider, width, polarity, idle level, phase, bit order and loopback are taken from their inputs only while `cfg_enable`=0. Changes to them while enabled have no effect.
- R11: `busy` stays high until the last bit time of the word has fully elapsed. `tx_ready` is high only when the engine is enabled, the transmitter is on and `busy` is low.
- R12: `rx_valid` is high for exactly one cycle per received word, in the cycle after the last bit time ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | 1 = operate, 0 = configuration mode |
| cfg_divider | input | 16 | Half-period length minus one, in module clocks |
| cfg_width_m1 | input | 5 | Word width minus one |
| cfg_polarity | input | 1 | `sclk` level in the first half of each bit |
| cfg_idle_level | input | 1 | `sclk` level between words |
| cfg_sample_first | input | 1 | 1 = sample on the first edge of a bit |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_loopback | input | 1 | 1 = receive from own `mosi` |
| tx_disable | input | 1 | Transmitter off |
| rx_disable | input | 1 | Receiver off |
| tx_data | input | 32 | Word to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Word accepted this cycle when `tx_valid` is high |
| rx_data | output | 32 | Last received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is being shifted |

## Verification
The condition hardest to reach from the ports is the frozen configuration. The bench has to show that settings changed while the engine runs are ignored, and the shifted word is the only place this can be seen. To do this, the bench keeps `cfg_enable` high, moves the divider and width inputs, and sends a word. The length of `busy` and the width of the returned word must still match the old settings. The phase and bit-order behaviour is judged by a bench-side slave. This slave counts `sclk` transitions, captures `mosi` on the edges where the programmed phase says sampling happens, and drives `miso` from its own word right after those edges. A wrong edge choice therefore corrupts both directions.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_end
);

    logic [DIV_W-1:0] cnt_q;

    assign half_end = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || half_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the half-period counter never passes the divider value
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div);

endmodule

// File: rtl/spi_word_path.sv
module spi_word_path #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              advance,
    input  logic              sample,
    input  logic              sample_bit,
    input  logic [IDX_W-1:0]  width_m1,
    input  logic              msb_first,
    output logic              cur_bit,
    output logic              next_bit,
    output logic              last,
    output logic [DATA_W-1:0] rx_next
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [IDX_W-1:0]  idx_q;

    function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] i);
        return msb_first ? (width_m1 - i) : i;
    endfunction

    assign cur_bit  = tx_q[bit_pos(idx_q)];
    assign next_bit = tx_q[bit_pos(idx_q + 1'b1)];
    assign last     = (idx_q == width_m1);

    always_comb begin
        rx_next = rx_q;
        if (sample) begin
            rx_next[bit_pos(idx_q)] = sample_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            tx_q  <= load_word;
            rx_q  <= '0;
            idx_q <= '0;
        end else begin
            if (sample) begin
                rx_q <= rx_next;
            end
            if (advance) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R3: a bit is never advanced past the last position of the word
    a_r3_no_advance_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [DIV_W-1:0]  cfg_divider,
    input  logic [IDX_W-1:0]  cfg_width_m1,
    input  logic              cfg_polarity,
    input  logic              cfg_idle_level,
    input  logic              cfg_sample_first,
    input  logic              cfg_msb_first,
    input  logic              cfg_loopback,
    input  logic              tx_disable,
    input  logic              rx_disable,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);

    import spi_eng_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [IDX_W-1:0] wm1;
        logic             pol;
        logic             idle;
        logic             ph;
        logic             msb;
        logic             loop;
    } eng_cfg_t;

    eng_cfg_t   cfg_q;
    eng_state_e state_q, state_d;
    logic       txo_q, rxo_q;
    logic       mosi_q, rx_valid_q;
    logic [DATA_W-1:0] rx_data_q;

    logic half_end, start, cur_bit, next_bit, last_bit;
    logic sample, advance, word_done, first_bit;
    logic [DATA_W-1:0] rx_next, load_word;

    // ---------------- configuration capture (config mode only)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{div: '0, wm1: IDX_W'(1), pol: 1'b0, idle: 1'b0,
                       ph: 1'b0, msb: 1'b0, loop: 1'b0};
        end else if (!cfg_enable) begin
            cfg_q.div  <= cfg_divider;
            cfg_q.wm1  <= (cfg_width_m1 == '0) ? IDX_W'(1) : cfg_width_m1;
            cfg_q.pol  <= cfg_polarity;
            cfg_q.idle <= cfg_idle_level;
            cfg_q.ph   <= cfg_sample_first;
            cfg_q.msb  <= cfg_msb_first;
            cfg_q.loop <= cfg_loopback;
        end
    end

    // ---------------- submodules
    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_enable && (state_q != ST_IDLE)),
        .div      (cfg_q.div),
        .half_end (half_end)
    );

    assign load_word = tx_disable ? '0 : tx_data;
    assign first_bit = tx_disable ? 1'b0
                     : tx_data[cfg_q.msb ? cfg_q.wm1 : IDX_W'(0)];

    assign sample  = cfg_enable && half_end &&
                     (((state_q == ST_LEAD) && cfg_q.ph) ||
                      ((state_q == ST_TRAIL) && !cfg_q.ph));
    assign advance   = cfg_enable && half_end && (state_q == ST_TRAIL) && !last_bit;
    assign word_done = cfg_enable && half_end && (state_q == ST_TRAIL) && last_bit;

    spi_word_path #(.DATA_W(DATA_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .load_word  (load_word),
        .advance    (advance),
        .sample     (sample),
        .sample_bit (cfg_q.loop ? mosi_q : miso),
        .width_m1   (cfg_q.wm1),
        .msb_first  (cfg_q.msb),
        .cur_bit    (cur_bit),
        .next_bit   (next_bit),
        .last       (last_bit),
        .rx_next    (rx_next)
    );

    // ---------------- state register
    always_comb begin
        start   = cfg_enable && (state_q == ST_IDLE) &&
                  (tx_disable ? !rx_disable : tx_valid);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_LEAD;
            ST_LEAD:  if (half_end) state_d = ST_TRAIL;
            ST_TRAIL: if (half_end) state_d = last_bit ? ST_IDLE : ST_LEAD;
            default:                state_d = ST_IDLE;
        endcase
        if (!cfg_enable) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- registered per-word data outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txo_q      <= 1'b0;
            rxo_q      <= 1'b0;
            mosi_q     <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= 1'b0;
            if (start) begin
                txo_q <= tx_disable;
                rxo_q <= rx_disable;
                if (tx_disable) begin
                    mosi_q <= 1'b0;
                end else if (cfg_q.ph) begin
                    mosi_q <= first_bit;
                end
            end else if (state_q == ST_IDLE && tx_disable) begin
                mosi_q <= 1'b0;
            end else if (cfg_enable && half_end) begin
                if (state_q == ST_LEAD && !cfg_q.ph) begin
                    mosi_q <= txo_q ? 1'b0 : cur_bit;
                end
                if (advance && cfg_q.ph) begin
                    mosi_q <= txo_q ? 1'b0 : next_bit;
                end
            end
            if (word_done && !rxo_q) begin
                rx_valid_q <= 1'b1;
                rx_data_q  <= rx_next;
            end
        end
    end

    // ---------------- combinational outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        tx_ready = cfg_enable && !tx_disable && (state_q == ST_IDLE);
        unique case (state_q)
            ST_LEAD:  sclk = cfg_q.pol;
            ST_TRAIL: sclk = !cfg_q.pol;
            default:  sclk = cfg_q.idle;
        endcase
    end

    assign mosi     = mosi_q;
    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;

    // ---------------- assertions
    a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !busy);

    a_r5_idle_clock_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg_q.idle));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && $past(cfg_enable)) |-> $stable(cfg_q));

    a_r8_txoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && txo_q) |-> !mosi);

    a_r9_rxoff_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(rxo_q));

endmodule

// File: tb/sim_spi_shift_engine.sv
module sim_spi_shift_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [15:0] cfg_divider = '0;
    logic [4:0]  cfg_width_m1 = 5'd7;
    logic        cfg_polarity = 1'b0, cfg_idle_level = 1'b0;
    logic        cfg_sample_first = 1'b1, cfg_msb_first = 1'b1, cfg_loopback = 1'b0;
    logic        tx_disable = 1'b0, rx_disable = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, rx_valid, sclk, mosi, busy;
    logic        miso = 1'b0;
    logic [31:0] rx_data;

    always #5 clk = ~clk;

    spi_shift_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_divider(cfg_divider), .cfg_width_m1(cfg_width_m1),
        .cfg_polarity(cfg_polarity), .cfg_idle_level(cfg_idle_level),
        .cfg_sample_first(cfg_sample_first), .cfg_msb_first(cfg_msb_first),
        .cfg_loopback(cfg_loopback), .tx_disable(tx_disable),
        .rx_disable(rx_disable), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
    );

    int vectors = 0, fails = 0;
    int b_n = 8, b_div = 0;
    bit b_pol = 0, b_idle = 0, b_ph = 1, b_msb = 1, b_loop = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    function automatic int spos(int k);
        return b_msb ? (b_n - 1 - k) : k;
    endfunction

    // ---------------- bench-side slave
    int          edge_n = 0, sk = 0;
    logic [31:0] sl_word = '0, cap = '0;

    always @(sclk) begin
        edge_n++;
        if (b_ph ? (edge_n % 2 == 1) : (edge_n % 2 == 0)) begin
            cap[spos(sk)] = mosi;
            sk = (sk + 1 == b_n) ? 0 : sk + 1;
            miso = sl_word[spos(sk)];
        end
    end

    // ---------------- scoreboard monitor
    logic [31:0] exp_q[$];
    bit          auto_mode = 0;
    logic [31:0] auto_exp = '0;
    int          rx_seen = 0;
    bit          prev_valid = 0;

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_seen++;
            if (prev_valid) chk("R12 pulse width", 32'd1, 32'd0);
            if (auto_mode) begin
                chk("R8 receive-only word", rx_data, auto_exp);
            end else if (exp_q.size() == 0) begin
                chk("R9/R12 unexpected rx_valid", 32'd1, 32'd0);
            end else begin
                chk("R3/R4/R6/R7 received word", rx_data, exp_q.pop_front());
            end
        end
        prev_valid = rx_valid;
    end

    // ---------------- driver tasks
    task automatic configure(int div, int wm1, bit pol, bit idl, bit ph, bit msb, bit lp);
        @(negedge clk);
        cfg_enable = 0;
        cfg_divider = 16'(div); cfg_width_m1 = 5'(wm1);
        cfg_polarity = pol; cfg_idle_level = idl;
        cfg_sample_first = ph; cfg_msb_first = msb; cfg_loopback = lp;
        @(negedge clk); @(negedge clk);
        cfg_enable = 1;
        b_div = div; b_n = (wm1 == 0) ? 2 : wm1 + 1;
        b_pol = pol; b_idle = idl; b_ph = ph; b_msb = msb; b_loop = lp;
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] tx, input logic [31:0] sw, input bit chk_cap);
        int cnt;
        logic [31:0] m;
        m = wmask(b_n);
        edge_n = 0; sk = 0; cap = '0; sl_word = sw;
        miso = sw[spos(0)];
        if (!rx_disable) exp_q.push_back(b_loop ? (tx & m) : (sw & m));
        chk("R11 ready while idle", {31'd0, tx_ready}, 32'd1);
        chk("R5 idle sclk level", {31'd0, sclk}, {31'd0, b_idle});
        tx_data = tx; tx_valid = 1;
        @(negedge clk);
        tx_valid = 0;
        chk("R11 busy after accept", {31'd0, busy}, 32'd1);
        chk("R11 no ready while busy", {31'd0, tx_ready}, 32'd0);
        chk("R5 first half level", {31'd0, sclk}, {31'd0, b_pol});
        cnt = 1;
        while (1) begin
            @(negedge clk);
            if (busy) cnt++; else break;
        end
        chk("R2 busy length", 32'(cnt), 32'(2 * b_n * (b_div + 1)));
        if (chk_cap) chk("R4/R6 word seen on mosi", cap, tx & m);
        @(negedge clk);
    endtask

    // ---------------- watchdog
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R11: watchdog expired, actual busy %0d expected run to end", busy);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // ---------------- main sequence
    initial begin
        int start_cnt;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        chk("R1 mosi", {31'd0, mosi}, 32'd0);
        chk("R1 tx_ready", {31'd0, tx_ready}, 32'd0);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);

        // mode-0 style, 8 bits, msb first
        configure(0, 7, 0, 0, 1, 1, 0);
        send(32'h0000_00A5, 32'h0000_003C, 1);

        // 16 bits, divider 2, polarity 1, late sampling, lsb first
        configure(2, 15, 1, 1, 0, 0, 0);
        send(32'h0000_BEEF, 32'h0000_1234, 1);

        // 32 bits, divider 1, late sampling, msb first
        configure(1, 31, 0, 0, 0, 1, 0);
        send(32'hDEAD_BEEF, 32'hCAFE_F00D, 1);

        // R3: width code 0 behaves as 2 bits; upper tx bits ignored, rx right-justified
        configure(0, 0, 1, 1, 1, 0, 0);
        send(32'hFFFF_FFFE, 32'hFFFF_FFFD, 1);

        // R7: loopback with miso driven with a different pattern
        configure(0, 11, 1, 1, 0, 0, 1);
        send(32'h0000_5ABC, 32'h0000_0543, 1);

        // R5: idle level differs from polarity (loopback, no slave capture)
        configure(1, 5, 0, 1, 1, 1, 1);
        send(32'h0000_002D, 32'h0, 0);

        // R10: change settings while enabled; old ones must stay in force
        @(negedge clk);
        cfg_divider = 16'd4; cfg_width_m1 = 5'd9;
        cfg_idle_level = 0; cfg_loopback = 0;
        @(negedge clk);
        send(32'h0000_0315, 32'h0, 0);
        chk("R10 settings frozen, sclk still at old idle", {31'd0, sclk}, 32'd1);

        // R9: receiver off
        configure(0, 7, 0, 0, 1, 1, 0);
        send(32'h0000_0011, 32'h0000_0022, 1);
        held = rx_data;
        rx_disable = 1;
        start_cnt = rx_seen;
        send(32'h0000_0099, 32'h0000_0077, 1);
        repeat (4) @(negedge clk);
        chk("R9 no strobe with receiver off", 32'(rx_seen), 32'(start_cnt));
        chk("R9 rx_data held", rx_data, held);
        rx_disable = 0;

        // R8: transmitter off, receive-only words
        edge_n = 0; sk = 0; sl_word = 32'h0000_0096;
        miso = sl_word[spos(0)];
        auto_exp = 32'h0000_0096; auto_mode = 1;
        start_cnt = rx_seen;
        tx_data = 32'hFFFF_FFFF;
        tx_disable = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (i % 8 == 3) begin
                chk("R8 mosi held low", {31'd0, mosi}, 32'd0);
                chk("R8 tx_ready low", {31'd0, tx_ready}, 32'd0);
            end
            if (rx_seen >= start_cnt + 3) break;
        end
        chk("R8 three receive-only words", 32'(rx_seen - start_cnt), 32'd3);
        tx_disable = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        auto_mode = 0;

        chk("R12 all expected words returned", 32'(exp_q.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule